// File: doc/BRIEF.md
# Dual-Path Floating-Point Adder

This block adds or subtracts two IEEE-754 single-precision numbers in a three-stage pipeline. Round to nearest even is the only rounding mode. It handles subnormal operands and results, infinities and NaNs. Each operation runs down one of two datapaths. The close path covers effective subtraction when the operand exponents differ by at most one. Heavy cancellation can happen only there, so this path carries a wide normalizing left shift but no alignment shift. The distant path covers every other case. It aligns the smaller operand with a long right shift, and afterwards it never needs more than a one-bit correction. The final stage takes the result of the path that was used, rounds it, packs it and raises the flags.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is delivered on an edge where `out_valid` and `out_ready` are both high. When the output holds a result that has not been taken (`out_ready` low), the whole pipeline freezes and `in_ready` goes low. The held result and its flags stay unchanged until the consumer takes them. `in_ready` never depends on `in_valid`.

Top module: `fpadd_dualpath`

## Requirements
- R1: For finite operands, the result (`in_a + in_b` when `in_op`=0, `in_a - in_b` when `in_op`=1) equals the exact sum rounded to nearest with ties to even, bit for bit.
- R2: Subnormal operands are used at their true value. A result below the normal range is returned as a subnormal with exponent field 0. A subnormal that rounds up to the smallest normal is returned with exponent field 1.
- R3: An exact zero from an effective subtraction is +0 (0x00000000). The sum of two zeros of the same sign keeps that sign, so -0 + -0 and -0 - +0 both give 0x80000000.
- R4: Any NaN input, or infinity minus infinity of the same sign, gives the quiet NaN 0x7FC00000. `out_invalid` is set for infinity minus infinity and for a signaling NaN input (fraction bit 22 clear), and is clear for a quiet NaN input.
- R5: An infinite operand, when the other operand is finite or an infinity of the same effective sign, gives an infinity of that sign with no flag set.
- R6: A finite result whose rounded magnitude reaches 2^128 gives an infinity of the result sign, with `out_overflow` and `out_inexact` set.
- R7: `out_inexact` is set exactly when the rounded finite result differs from the exact sum.
- R8: With `out_ready` held high, a result appears on `out_valid` after the third rising edge counted from the accepting edge, which is counted as the first.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_result` and the flags hold their values.
- R10: Effective subtraction with an exponent difference of 0 or 1 gives the exact difference, normalized by as many places as the cancellation needs. This covers differences of a single unit in the last place.
- R11: During and after reset, `out_valid` is low and `in_ready` is high. An operation that is in flight when reset is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word is valid |
| in_ready | output | 1 | Block can take an operand word |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| in_op | input | 1 | 0 adds, 1 subtracts `in_b` from `in_a` |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Rounded result, single precision |
| out_invalid | output | 1 | Invalid-operation flag |
| out_overflow | output | 1 | Overflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The assertions assume that `out_ready` is a known level at each rising edge and that it may fall at any time, including while a result is pending. The normalization checks in both paths assume that the operands held in the first stage are not infinity or NaN. The assertions mask those operands out themselves, so any bit pattern may be driven. The stimulus sets every input half a cycle away from the sampling edge. It toggles `out_ready` at random during the streamed phase. It deliberately mixes random words, operands with neighbouring exponents, operands near the subnormal range and operands that differ only in their low fraction bits, so that both paths and the special-value decode are exercised.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int GRS_W  = 3;
  localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

  typedef struct packed {
    logic nan;
    logic inf;
    logic sign;
    logic invalid;
  } spec_t;

  typedef struct packed {
    logic             sx;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mx;
    logic [MAN_W-1:0] my;
    logic [EXP_W-1:0] dexp;
    logic             eff_sub;
    logic             near;
  } opnd_t;

  typedef struct packed {
    logic             sign;
    logic [EXT_W-1:0] exp;
    logic [MAN_W-1:0] man;
    logic             grd;
    logic             stk;
  } path_t;
endpackage

// File: rtl/fpadd_far_path.sv
module fpadd_far_path
  import fpadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld,
  input  logic  plain,
  input  opnd_t op,
  output path_t res
);
  localparam int AW = MAN_W + GRS_W;

  logic [AW-1:0] xa, ya, ysh;
  logic          lost;
  logic [AW:0]   sum;

  always_comb begin
    xa = {op.mx, {GRS_W{1'b0}}};
    ya = {op.my, {GRS_W{1'b0}}};
    if (op.dexp >= EXP_W'(AW)) begin
      ysh  = '0;
      lost = |op.my;
    end else begin
      ysh  = ya >> op.dexp;
      lost = |(ya & (({{(AW-1){1'b0}}, 1'b1} << op.dexp) - {{(AW-1){1'b0}}, 1'b1}));
    end
    ysh[0] = ysh[0] | lost;
    sum = op.eff_sub ? ({1'b0, xa} - {1'b0, ysh}) : ({1'b0, xa} + {1'b0, ysh});
    res.sign = op.sx;
    if (sum[AW]) begin
      res.man = sum[AW -: MAN_W];
      res.grd = sum[AW-MAN_W];
      res.stk = |sum[AW-MAN_W-1:0];
      res.exp = EXT_W'(op.ex) + EXT_W'(1);
    end else if (sum[AW-1] || !op.eff_sub) begin
      res.man = sum[AW-1 -: MAN_W];
      res.grd = sum[AW-1-MAN_W];
      res.stk = |sum[AW-2-MAN_W:0];
      res.exp = EXT_W'(op.ex);
    end else begin
      res.man = sum[AW-2 -: MAN_W];
      res.grd = sum[AW-2-MAN_W];
      res.stk = sum[0];
      res.exp = EXT_W'(op.ex) - EXT_W'(1);
    end
  end

  // R1: after alignment and the one-place correction the far result is normalized
  assert_far_normalized_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && plain && !op.near) |-> (res.man[MAN_W-1] || res.exp == EXT_W'(1)));
endmodule

// File: rtl/fpadd_near_path.sv
module fpadd_near_path
  import fpadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld,
  input  logic  plain,
  input  opnd_t op,
  output path_t res
);
  localparam int NW = MAN_W + 1;

  logic [NW-1:0]    xa, ya, mag, norm;
  logic [NW:0]      diff;
  logic             neg;
  logic [EXT_W-1:0] lz, cap, sh;

  always_comb begin
    xa   = {op.mx, 1'b0};
    ya   = (op.dexp == '0) ? {op.my, 1'b0} : {1'b0, op.my};
    diff = {1'b0, xa} - {1'b0, ya};
    neg  = diff[NW];
    mag  = neg ? (ya - xa) : diff[NW-1:0];
    lz   = EXT_W'(NW);
    for (int i = 0; i < NW; i++) begin
      if (mag[i]) lz = EXT_W'(NW - 1 - i);
    end
    cap  = EXT_W'(op.ex) - EXT_W'(1);
    sh   = (lz < cap) ? lz : cap;
    norm = mag << sh;
    res.exp  = EXT_W'(op.ex) - sh;
    res.man  = norm[NW-1:1];
    res.grd  = norm[0];
    res.stk  = 1'b0;
    res.sign = (mag == '0) ? 1'b0 : (op.sx ^ neg);
  end

  // R10: the cancellation shift leaves a leading one, or stops at the subnormal floor
  assert_near_normalized_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && plain && op.near && op.eff_sub) |->
      (res.man[MAN_W-1] || res.exp == EXT_W'(1) || res.man == '0));
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  path_t              p,
  input  spec_t              sp,
  output logic [WORD_W-1:0]  word,
  output logic               f_inv,
  output logic               f_ovf,
  output logic               f_inx
);
  logic             up;
  logic [MAN_W:0]   mr;
  logic [MAN_W-1:0] m2;
  logic [EXT_W-1:0] e2;

  always_comb begin
    up = p.grd & (p.stk | p.man[0]);
    mr = {1'b0, p.man} + {{MAN_W{1'b0}}, up};
    if (mr[MAN_W]) begin
      m2 = mr[MAN_W:1];
      e2 = p.exp + EXT_W'(1);
    end else begin
      m2 = mr[MAN_W-1:0];
      e2 = p.exp;
    end
    f_inv = 1'b0;
    f_ovf = 1'b0;
    f_inx = 1'b0;
    if (sp.nan) begin
      word  = {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};
      f_inv = sp.invalid;
    end else if (sp.inf) begin
      word = {sp.sign, EXP_ALL1, {FRAC_W{1'b0}}};
    end else if (e2 >= EXT_W'(EXP_ALL1)) begin
      word  = {p.sign, EXP_ALL1, {FRAC_W{1'b0}}};
      f_ovf = 1'b1;
      f_inx = 1'b1;
    end else begin
      word  = {p.sign, m2[MAN_W-1] ? e2[EXP_W-1:0] : {EXP_W{1'b0}}, m2[FRAC_W-1:0]};
      f_inx = p.grd | p.stk;
    end
  end
endmodule

// File: rtl/fpadd_dualpath.sv
module fpadd_dualpath
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_overflow,
  output logic              out_inexact
);
  logic             v1, v2, v3, adv;
  opnd_t            op_n, s1_op;
  spec_t            sp_n, s1_sp, s2_sp;
  path_t            far_res, near_res, path_n, s2_path;
  logic [WORD_W-1:0] word_n;
  logic             inv_n, ovf_n, inx_n, s1_plain;

  logic             sa, sb, swap, a_nan, b_nan, a_inf, b_inf, inf_clash;
  logic [EXP_W-1:0] ea, eb, ea_e, eb_e, ey;
  logic [FRAC_W-1:0] fa, fb;

  assign adv      = !v3 || out_ready;
  assign in_ready = adv;
  assign out_valid = v3;

  // Stage 1: decode, swap by exponent, pick the path
  always_comb begin
    sa    = in_a[WORD_W-1];
    sb    = in_b[WORD_W-1] ^ in_op;
    ea    = in_a[WORD_W-2 -: EXP_W];
    eb    = in_b[WORD_W-2 -: EXP_W];
    fa    = in_a[FRAC_W-1:0];
    fb    = in_b[FRAC_W-1:0];
    a_nan = (ea == EXP_ALL1) && (fa != '0);
    b_nan = (eb == EXP_ALL1) && (fb != '0);
    a_inf = (ea == EXP_ALL1) && (fa == '0);
    b_inf = (eb == EXP_ALL1) && (fb == '0);
    ea_e  = (ea == '0) ? EXP_W'(1) : ea;
    eb_e  = (eb == '0) ? EXP_W'(1) : eb;
    swap  = ea_e < eb_e;
    op_n.sx      = swap ? sb : sa;
    op_n.ex      = swap ? eb_e : ea_e;
    ey           = swap ? ea_e : eb_e;
    op_n.mx      = swap ? {eb != '0, fb} : {ea != '0, fa};
    op_n.my      = swap ? {ea != '0, fa} : {eb != '0, fb};
    op_n.dexp    = op_n.ex - ey;
    op_n.eff_sub = sa ^ sb;
    op_n.near    = op_n.eff_sub && (op_n.dexp <= EXP_W'(1));
    inf_clash    = a_inf && b_inf && op_n.eff_sub;
    sp_n.nan     = a_nan || b_nan || inf_clash;
    sp_n.invalid = (a_nan && !fa[FRAC_W-1]) || (b_nan && !fb[FRAC_W-1]) || inf_clash;
    sp_n.inf     = a_inf || b_inf;
    sp_n.sign    = a_inf ? sa : sb;
  end

  assign s1_plain = !s1_sp.nan && !s1_sp.inf;

  fpadd_far_path u_far (
    .clk(clk), .rst_n(rst_n), .vld(v1), .plain(s1_plain), .op(s1_op), .res(far_res)
  );

  fpadd_near_path u_near (
    .clk(clk), .rst_n(rst_n), .vld(v1), .plain(s1_plain), .op(s1_op), .res(near_res)
  );

  assign path_n = s1_op.near ? near_res : far_res;

  fpadd_round u_round (
    .p(s2_path), .sp(s2_sp), .word(word_n), .f_inv(inv_n), .f_ovf(ovf_n), .f_inx(inx_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1           <= 1'b0;
      v2           <= 1'b0;
      v3           <= 1'b0;
      s1_op        <= '0;
      s1_sp        <= '0;
      s2_path      <= '0;
      s2_sp        <= '0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_overflow <= 1'b0;
      out_inexact  <= 1'b0;
    end else if (adv) begin
      v1           <= in_valid;
      v2           <= v1;
      v3           <= v2;
      s1_op        <= op_n;
      s1_sp        <= sp_n;
      s2_path      <= path_n;
      s2_sp        <= s1_sp;
      out_result   <= word_n;
      out_invalid  <= inv_n;
      out_overflow <= ovf_n;
      out_inexact  <= inx_n;
    end
  end

  // R9: a pending result is frozen until the consumer takes it
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_invalid) && $stable(out_overflow) && $stable(out_inexact)));

  // R4: the invalid flag only ever accompanies a quiet NaN
  assert_invalid_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |->
      (out_result[WORD_W-2 -: EXP_W] == EXP_ALL1 && out_result[FRAC_W-1]));

  // R6: overflow always yields an infinity and is inexact
  assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |->
      (out_result[WORD_W-2:0] == {EXP_ALL1, {FRAC_W{1'b0}}} && out_inexact));
endmodule

// File: tb/sim_fpadd_dualpath.sv
`timescale 1ns/1ps
module sim_fpadd_dualpath;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, in_op, out_valid, out_ready;
  logic [31:0] in_a, in_b, out_result;
  logic        out_invalid, out_overflow, out_inexact;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpadd_dualpath u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid),
    .out_overflow(out_overflow), .out_inexact(out_inexact)
  );

  // {a, b, op, expected result, expected {invalid, overflow, inexact}, requirement}
  localparam int NV = 19;
  localparam logic [103:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 3'b000, 4'd1},  // R1 1+1
    {32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 3'b000, 4'd1},  // R1 3-1
    {32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 3'b000, 4'd3},  // R3
    {32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 3'b000, 4'd3},  // R3
    {32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 3'b000, 4'd3},  // R3
    {32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 3'b000, 4'd3},  // R3
    {32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 3'b000, 4'd10}, // R10 d=0
    {32'h40000000, 32'h3FFFFFFF, 1'b1, 32'h34000000, 3'b000, 4'd10}, // R10 d=1
    {32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 3'b000, 4'd10}, // R10 d=1
    {32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 3'b000, 4'd2},  // R2
    {32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, 3'b000, 4'd2},  // R2
    {32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 3'b100, 4'd4},  // R4 inf-inf
    {32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 3'b000, 4'd4},  // R4 quiet
    {32'h7F800001, 32'h00000000, 1'b0, 32'h7FC00000, 3'b100, 4'd4},  // R4 signaling
    {32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 3'b000, 4'd5},  // R5
    {32'h3F800000, 32'hFF800000, 1'b1, 32'h7F800000, 3'b000, 4'd5},  // R5
    {32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 3'b011, 4'd6},  // R6
    {32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 3'b001, 4'd7},  // R7 tie to even
    {32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 3'b001, 4'd7}   // R7 above half
  };

  task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Exact reference: values as integers in units of 2^-149, rounded afterwards
  function automatic logic [34:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic op);
    logic sa, sb, sg, an, bn, ai, bi, ovf;
    logic [7:0] ea, eb;
    logic [319:0] va, vb, mag, rem, half;
    logic [24:0] m;
    int p, sh, e;
    sa = a[31]; sb = b[31] ^ op; ea = a[30:23]; eb = b[30:23];
    an = (ea == 8'hFF) && (a[22:0] != 0); bn = (eb == 8'hFF) && (b[22:0] != 0);
    ai = (ea == 8'hFF) && (a[22:0] == 0); bi = (eb == 8'hFF) && (b[22:0] == 0);
    if (an || bn || (ai && bi && sa != sb))
      return {((an && !a[22]) || (bn && !b[22]) || (ai && bi && sa != sb)), 2'b00, 32'h7FC00000};
    if (ai) return {3'b000, sa, 31'h7F800000};
    if (bi) return {3'b000, sb, 31'h7F800000};
    va = 320'({ea != 0, a[22:0]}) << ((ea == 0) ? 0 : ea - 1);
    vb = 320'({eb != 0, b[22:0]}) << ((eb == 0) ? 0 : eb - 1);
    if (sa == sb) begin mag = va + vb; sg = sa; end
    else if (va >= vb) begin mag = va - vb; sg = sa; end
    else begin mag = vb - va; sg = sb; end
    if (mag == 0) return {3'b000, (sa == sb) ? sa : 1'b0, 31'h0};
    p = 0;
    for (int i = 0; i < 320; i++) if (mag[i]) p = i;
    if (p <= 23) return {3'b000, sg, m[0] & 1'b0 | (mag[23] ? 8'd1 : 8'd0), mag[22:0]};
    sh = p - 23;
    m = 25'(mag >> sh);
    rem = mag & ((320'd1 << sh) - 320'd1);
    half = 320'd1 << (sh - 1);
    e = sh + 1;
    if (rem > half || (rem == half && m[0])) m = m + 25'd1;
    if (m[24]) begin m = m >> 1; e = e + 1; end
    ovf = (e >= 255);
    if (ovf) return {3'b011, sg, 31'h7F800000};
    return {2'b00, rem != 0, sg, e[7:0], m[22:0]};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic op);
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1;
    while (1) begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic recv(output logic [34:0] r);
    while (1) begin
      @(negedge clk);
      #1;
      if (out_valid && out_ready) begin
        r = {out_invalid, out_overflow, out_inexact, out_result};
        break;
      end
    end
    @(posedge clk);
  endtask

  task automatic run1(input logic [31:0] a, input logic [31:0] b, input logic op, output logic [34:0] r);
    send(a, b, op);
    @(negedge clk) in_valid = 1'b0;
    recv(r);
  endtask

  localparam int NR = 400;
  logic [31:0] ra [NR];
  logic [31:0] rb [NR];
  logic        rop [NR];
  int stall_viol = 0;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_sim();
  end

  initial begin
    logic [34:0] r, ex, held;
    int n;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_a = '0; in_b = '0; in_op = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11: reset state with the consumer not ready
    chk(!out_valid && in_ready, "R11 reset state", {33'd0, out_valid, in_ready}, 35'd1);

    out_ready = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run1(VEC[i][103:72], VEC[i][71:40], VEC[i][39], r);
      ex = {VEC[i][6:4], VEC[i][38:7]};
      checks++;
      if (r !== ex) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][3:0], i, r, ex);
      end
    end

    // R8: latency of three edges with the consumer always ready
    send(32'h40000000, 32'h40400000, 1'b0);
    @(negedge clk) in_valid = 1'b0;
    #1; n = 1;
    while (!out_valid && n < 10) begin @(negedge clk); #1; n++; end
    chk(n == 3, "R8 latency", 35'(n), 35'd3);
    chk({out_invalid, out_overflow, out_inexact, out_result} == 35'h040A00000, "R8 R1 2+3",
        {out_invalid, out_overflow, out_inexact, out_result}, 35'h040A00000);
    @(posedge clk);

    // R9: back-pressure holds the result and blocks input
    @(negedge clk) out_ready = 1'b0;
    send(32'h3F800000, 32'h3F800000, 1'b0);
    @(negedge clk) in_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    held = {out_invalid, out_overflow, out_inexact, out_result};
    chk(out_valid && !in_ready, "R9 stalled handshake", {33'd0, out_valid, in_ready}, 35'd2);
    repeat (3) @(negedge clk);
    #1;
    chk({out_invalid, out_overflow, out_inexact, out_result} == held && out_valid, "R9 held result",
        {out_invalid, out_overflow, out_inexact, out_result}, held);
    chk(held == 35'h040000000, "R9 R1 held value", held, 35'h040000000);
    @(negedge clk) out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    chk(!out_valid, "R9 drained", {34'd0, out_valid}, 35'd0);

    // R11: an operation in flight when reset hits is dropped
    send(32'h3F800000, 32'h3F800000, 1'b0);
    @(negedge clk) in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R11 reset mid-flight", {33'd0, out_valid, in_ready}, 35'd1);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!out_valid, "R11 no stale result", {34'd0, out_valid}, 35'd0);

    // R1 R2 R7 R10: streamed random operands against the exact reference
    for (int i = 0; i < NR; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      case (i % 4)
        1: b = {b[31], a[30:23] + {7'd0, b[0]}, b[22:0]};
        2: begin a[30:24] = '0; b[30:24] = '0; end
        3: b = a ^ (b & 32'h000000FF);
        default: ;
      endcase
      ra[i] = a; rb[i] = b; rop[i] = ($urandom % 2) == 1;
    end
    fork
      begin
        for (int i = 0; i < NR; i++) send(ra[i], rb[i], rop[i]);
        @(negedge clk) in_valid = 1'b0;
      end
      begin
        for (int j = 0; j < NR; j++) begin
          logic [34:0] got, want;
          while (1) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #1;
            if (out_valid && !out_ready && in_ready) stall_viol++;
            if (out_valid && out_ready) break;
          end
          got = {out_invalid, out_overflow, out_inexact, out_result};
          want = ref_add(ra[j], rb[j], rop[j]);
          checks++;
          if (got !== want) begin
            errors++;
            $display("FAIL R1 stream %0d a=%h b=%h op=%0d actual=%h expected=%h",
                     j, ra[j], rb[j], rop[j], got, want);
          end
          @(posedge clk);
        end
      end
    join
    chk(stall_viol == 0, "R9 in_ready during stalls", 35'(stall_viol), 35'd0);
    finish_sim();
  end
endmodule